// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block holds the programmed operating mode of a synchronous DRAM device and turns each column command into the column address stream for the burst. A mode-set command loads burst length, burst ordering, read latency and write mode from the address bus. Any field code the device does not define is refused: the stored mode stays unchanged and a sticky error flag is raised.

A READ or WRITE command starts a burst at the column given on the address bus. One beat follows per cycle, in sequential or interleaved order inside an aligned block of the burst length. A full-page burst runs over all 512 columns of the row and wraps until a terminate command or a new column command stops it. Write beats come out as a write strobe that the data mask gates in the same cycle. Read beats come out as a data-valid window delayed by the programmed latency, and the data mask gates it two cycles after the mask is sampled. The storage array sits outside this block.

Top module: `sdr_burst_ctl`

## Requirements
- R1: After reset, burst_o, wr_en_o, rd_valid_o and mode_err_o are 0. The mode is burst length 1, sequential, latency 2, burst writes.
- R2: cmd_i encodes 0=NOP, 1=mode set, 2=READ, 3=WRITE, 4=terminate. Codes 5 to 7 act as NOP.
- R3: On a mode set, addr_i[2:0] selects the length (000=1, 001=2, 010=4, 011=8, 111=full page of 512, full page only with sequential). addr_i[3] selects the order (0 sequential, 1 interleaved). addr_i[6:4] selects the latency (010=2, 011=3). addr_i[9] selects the write mode (1 = single-beat writes). addr_i[8:7] must be 0, and addr_i[11:10] are ignored.
- R4: A mode set carrying any other code leaves the old mode and sets mode_err_o in the next cycle. A valid mode set clears mode_err_o.
- R5: A READ or WRITE in cycle c gives burst_o=1 and col_o=addr_i[8:0] in cycle c+1, with beat k in cycle c+1+k, for length L beats.
- R6: In sequential order, beat k is the start column with its low log2(L) bits replaced by (start+k) mod L.
- R7: In interleaved order, beat k is the start column with its low log2(L) bits XORed with k.
- R8: A full-page burst wraps from column 511 to 0 and continues until it is stopped.
- R9: A terminate drops burst_o in the next cycle. A READ or WRITE during a burst restarts it at the new column.
- R10: In single-beat write mode, a WRITE lasts one beat while a READ keeps the programmed length.
- R11: wr_en_o is high exactly in write-burst beats whose dqm_i is low in that same cycle.
- R12: For a READ in cycle c, rd_valid_o is high from cycle c+latency for L cycles.
- R13: dqm_i high in cycle d forces rd_valid_o low in cycle d+2.
- R14: A mode set issued while burst_o is high changes neither the mode nor mode_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command |
| addr_i | input | 12 | Mode field on a mode set, column on READ/WRITE |
| dqm_i | input | 1 | Data mask |
| col_o | output | 9 | Column of the current beat |
| burst_o | output | 1 | Burst beat in progress |
| wr_en_o | output | 1 | Unmasked write beat |
| rd_valid_o | output | 1 | Read data valid window |
| mode_err_o | output | 1 | Last accepted mode set was refused |

## Verification
The bench starts bursts at columns whose low bits are not zero. A sequencer that carries into the upper column bits, or that confuses XOR with add, then returns wrong columns from the second beat on. A full-page read is started at column 510 to catch a counter that saturates or leaves the row instead of wrapping. For the read window, the latency and the mask timing are each checked cycle by cycle, so a pipeline one stage short or long shows up as a shifted window or as a hole in the wrong beat. Refused mode codes and mode sets issued during a burst are followed by a burst whose length shows whether the stored mode was changed anyway.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_MRS  = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;
  localparam logic [2:0] CMD_WR   = 3'd3;
  localparam logic [2:0] CMD_TERM = 3'd4;

  localparam int unsigned MAX_CL = 3;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] cas_lat;
    logic       ilv;
    logic [2:0] bl_code;
  } mode_t;

  localparam mode_t MODE_RST = '{wr_single: 1'b0, cas_lat: 2'd2, ilv: 1'b0, bl_code: 3'd0};
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_t             mode_o,
  output logic              err_o
);
  logic  bl_ok, cl_ok, pad_ok, all_ok;
  mode_t nxt;

  always_comb begin
    nxt.bl_code   = addr_i[2:0];
    nxt.ilv       = addr_i[3];
    nxt.cas_lat   = addr_i[5:4];
    nxt.wr_single = addr_i[9];
    bl_ok  = (addr_i[2:0] <= 3'd3) || (addr_i[2:0] == 3'd7 && !addr_i[3]);
    cl_ok  = (addr_i[6:4] == 3'b010) || (addr_i[6:4] == 3'b011);
    pad_ok = (addr_i[8:7] == 2'b00);
    all_ok = bl_ok && cl_ok && pad_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
      err_o  <= 1'b0;
    end else if (load_i) begin
      if (all_ok) mode_o <= nxt;
      err_o <= !all_ok;
    end
  end
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_wr_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             act_o,
  output logic             wr_o
);
  logic [COL_W-1:0] start_q, cnt_q, mask_q, mask_d, ofs;
  logic             ilv_q, full_q;
  logic             single_d;

  always_comb begin
    single_d = is_wr_i && wr_single_i;
    unique case (bl_code_i)
      3'd0:    mask_d = '0;
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      default: mask_d = '1;
    endcase
    if (single_d) mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o   <= 1'b0;
      wr_o    <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
    end else if (start_i) begin
      act_o   <= 1'b1;
      wr_o    <= is_wr_i;
      start_q <= col_i;
      cnt_q   <= '0;
      mask_q  <= mask_d;
      ilv_q   <= ilv_i;
      full_q  <= (bl_code_i == 3'd7) && !single_d;
    end else if (act_o) begin
      if (term_i || (!full_q && cnt_q == mask_q)) act_o <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ofs   = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign col_o = (start_q & ~mask_q) | (ofs & mask_q);
endmodule

// File: rtl/sdr_rd_window.sv
module sdr_rd_window #(
  parameter int unsigned MAX_CL = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       beat_i,
  input  logic       dqm_i,
  input  logic [1:0] cas_lat_i,
  output logic       valid_o
);
  localparam int unsigned DEPTH = MAX_CL - 1;
  localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] pipe_q;
  logic [1:0]       dqm_q;
  logic [IW-1:0]    sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= beat_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= 1'b0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dqm_q <= '0;
    else         dqm_q <= {dqm_q[0], dqm_i};
  end

  assign sel     = IW'(cas_lat_i - 2'd2);
  assign valid_o = pipe_q[sel] && !dqm_q[1];
endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl
  import sdr_burst_pkg::*;
#(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic              burst_o,
  output logic              wr_en_o,
  output logic              rd_valid_o,
  output logic              mode_err_o
);
  mode_t mode;
  logic  is_rd, is_wr, wr_act;

  assign is_rd = (cmd_i == CMD_RD);
  assign is_wr = (cmd_i == CMD_WR);

  sdr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cmd_i == CMD_MRS && !burst_o),
    .addr_i (addr_i),
    .mode_o (mode),
    .err_o  (mode_err_o)
  );

  sdr_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (is_rd || is_wr),
    .is_wr_i     (is_wr),
    .term_i      (cmd_i == CMD_TERM),
    .col_i       (addr_i[COL_W-1:0]),
    .bl_code_i   (mode.bl_code),
    .ilv_i       (mode.ilv),
    .wr_single_i (mode.wr_single),
    .col_o       (col_o),
    .act_o       (burst_o),
    .wr_o        (wr_act)
  );

  sdr_rd_window #(.MAX_CL(MAX_CL)) u_rdw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (burst_o && !wr_act),
    .dqm_i     (dqm_i),
    .cas_lat_i (mode.cas_lat),
    .valid_o   (rd_valid_o)
  );

  assign wr_en_o = burst_o && wr_act && !dqm_i;
endmodule

// File: rtl/sdr_burst_chk.sv
module sdr_burst_chk #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dqm_i,
  input logic [COL_W-1:0]  col_o,
  input logic              burst_o,
  input logic              wr_en_o,
  input logic              rd_valid_o,
  input logic              mode_err_o
);
  assert_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd2 || cmd_i == 3'd3) |=> burst_o && col_o == $past(addr_i[COL_W-1:0]));

  assert_term_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4) |=> !burst_o);

  assert_wmask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> burst_o && !dqm_i);

  assert_rmask_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dqm_i, 2) |-> !rd_valid_o);

  assert_refuse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && !burst_o && addr_i[8:7] != 2'b00) |=> mode_err_o);

  assert_busy_mrs_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && burst_o) |=> $stable(mode_err_o));
endmodule

bind sdr_burst_ctl sdr_burst_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sdr_burst_ctl.sv
`timescale 1ns/1ps
module sim_sdr_burst_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [11:0] addr = '0;
  logic        dqm = 1'b0;
  logic [8:0]  col;
  logic        burst, wr_en, rd_valid, mode_err;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdr_burst_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .addr_i(addr), .dqm_i(dqm),
    .col_o(col), .burst_o(burst), .wr_en_o(wr_en), .rd_valid_o(rd_valid),
    .mode_err_o(mode_err)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // drive one cycle of inputs, return mid-cycle
  task automatic tick(input logic [2:0] c, input logic [11:0] a, input logic m);
    @(posedge clk); #1;
    cmd = c; addr = a; dqm = m;
    @(negedge clk);
  endtask

  function automatic int ecol(int s, int k, int len, bit ilv);
    int m = len - 1;
    return (s & ~m & 511) | ((ilv ? (s ^ k) : (s + k)) & m);
  endfunction

  task automatic set_mode(input logic [11:0] a);
    tick(3'd1, a, 1'b0);
    tick(3'd0, '0, 1'b0);
  endtask

  task automatic run_burst(input string tag, input bit wr, input int s, input int len, input bit ilv);
    tick(wr ? 3'd3 : 3'd2, 12'(s), 1'b0);
    for (int k = 0; k < len; k++) begin
      tick(3'd0, '0, 1'b0);
      chk({tag, " burst"}, burst, 1);
      chk({tag, " col"}, col, ecol(s, k, len, ilv));
      if (wr) chk({tag, " R11 wr_en"}, wr_en, 1);
    end
    tick(3'd0, '0, 1'b0);
    chk({tag, " end"}, burst, 0);
  endtask

  task automatic t_reset;
    chk("R1 burst", burst, 0); chk("R1 wr_en", wr_en, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 err", mode_err, 0);
    run_burst("R1 default len1", 1'b0, 5, 1, 1'b0);
  endtask

  task automatic t_seq;
    set_mode(12'h022);
    run_burst("R6 seq4 rd", 1'b0, 6, 4, 1'b0);
    run_burst("R6 seq4 wr", 1'b1, 9'h1F3, 4, 1'b0);
  endtask

  task automatic t_ilv;
    set_mode(12'h02B);
    run_burst("R7 ilv8 wr", 1'b1, 5, 8, 1'b1);
    set_mode(12'h029);
    run_burst("R7 ilv2 rd", 1'b0, 9'h0C7, 2, 1'b1);
  endtask

  task automatic t_full;
    set_mode(12'h027);
    tick(3'd2, 12'd510, 1'b0);
    for (int k = 0; k < 6; k++) begin
      tick(3'd0, '0, 1'b0);
      chk("R8 full col", col, (510 + k) % 512);
    end
    tick(3'd4, '0, 1'b0);
    chk("R9 term cycle still on", burst, 1);
    tick(3'd0, '0, 1'b0);
    chk("R9 term stops", burst, 0);
  endtask

  task automatic t_restart;
    set_mode(12'h023);
    tick(3'd2, 12'd0, 1'b0);
    tick(3'd0, '0, 1'b0);
    tick(3'd2, 12'h045, 1'b0);
    tick(3'd0, '0, 1'b0);
    chk("R9 restart col0", col, 9'h045);
    tick(3'd0, '0, 1'b0);
    chk("R9 restart col1", col, 9'h046);
    for (int k = 0; k < 7; k++) tick(3'd0, '0, 1'b0);
    chk("R9 restart end", burst, 0);
  endtask

  task automatic t_reserved;
    set_mode(12'h021);
    chk("R4 valid err", mode_err, 0);
    set_mode(12'h024);
    chk("R4 bl100 err", mode_err, 1);
    run_burst("R4 mode kept", 1'b0, 3, 2, 1'b0);
    set_mode(12'h02F); chk("R4 full+ilv err", mode_err, 1);
    set_mode(12'h042); chk("R4 cl4 err", mode_err, 1);
    set_mode(12'h121); chk("R3 a8 err", mode_err, 1);
    set_mode(12'hC21); chk("R3 a11a10 ignored", mode_err, 0);
    run_burst("R3 after C21", 1'b0, 3, 2, 1'b0);
  endtask

  task automatic t_busy_mrs;
    set_mode(12'h023);
    tick(3'd2, 12'd0, 1'b0);
    tick(3'd0, '0, 1'b0);
    tick(3'd1, 12'h024, 1'b0);
    tick(3'd1, 12'h020, 1'b0);
    chk("R14 err unchanged", mode_err, 0);
    for (int k = 0; k < 8; k++) tick(3'd0, '0, 1'b0);
    chk("R14 err still", mode_err, 0);
    run_burst("R14 len kept", 1'b0, 2, 8, 1'b0);
  endtask

  task automatic t_single;
    set_mode(12'h222);
    run_burst("R10 wr single", 1'b1, 6, 1, 1'b0);
    run_burst("R10 rd full len", 1'b0, 6, 4, 1'b0);
  endtask

  task automatic t_wmask;
    set_mode(12'h022);
    tick(3'd3, 12'd0, 1'b0);
    tick(3'd0, '0, 1'b0); chk("R11 beat0", wr_en, 1);
    tick(3'd0, '0, 1'b1); chk("R11 masked beat1", wr_en, 0);
    tick(3'd0, '0, 1'b0); chk("R11 beat2", wr_en, 1);
    tick(3'd0, '0, 1'b0); chk("R11 beat3", wr_en, 1);
    tick(3'd0, '0, 1'b0); chk("R11 idle", wr_en, 0);
  endtask

  task automatic t_rdwin;
    int exp2[6] = '{0, 1, 1, 1, 1, 0};
    int exp3[7] = '{0, 0, 1, 0, 1, 1, 0};
    set_mode(12'h022);
    tick(3'd2, 12'd0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      tick(3'd0, '0, 1'b0);
      chk("R12 cl2 window", rd_valid, exp2[k]);
    end
    set_mode(12'h032);
    tick(3'd2, 12'd0, 1'b0);
    for (int k = 0; k < 7; k++) begin
      tick(3'd0, '0, k == 1);
      chk("R13 cl3 window masked", rd_valid, exp3[k]);
    end
  endtask

  task automatic t_cmd_codes;
    set_mode(12'h022);
    tick(3'd5, 12'd7, 1'b0);
    tick(3'd7, 12'd7, 1'b0);
    chk("R2 code5 nop", burst, 0);
    tick(3'd0, '0, 1'b0);
    chk("R2 code7 nop", burst, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_full();
    t_restart();
    t_reserved();
    t_busy_mrs();
    t_single();
    t_wmask();
    t_rdwin();
    t_cmd_codes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule